// File: doc/BRIEF.md
# Sequential Modular Inverter (Extended Euclid)

This block computes the multiplicative inverse Z of an N-bit operand A modulo an N-bit modulus p, so that A·Z ≡ 1 (mod p). It runs the extended Euclidean algorithm one iteration at a time. Each iteration first performs a full restoring division of the older remainder by the newer one, which gives a quotient and a remainder. It then rotates the remainder pair and updates a signed Bézout coefficient pair, forming the product of the quotient and a coefficient in a sequential shift-add unit.

The host presents A and p with a one-cycle start pulse while the unit is idle. The unit raises busy and works through as many iterations as the data needs. When it finishes it drops busy and pulses done for one cycle, with the result and an error flag. The error flag means that no inverse exists: A is 0, A shares a factor with p, or p is below 2. The result and the flag stay on the outputs until the next operation completes.

Top module: `modinv_top`

## Requirements
- R1: While reset is held and in the first cycle after it, busy_o, done_o, err_o and z_o are all 0.
- R2: A start_i sampled high while busy_o is low sets busy_o in the next cycle. A start_i sampled while busy_o is high is ignored, and its operands have no effect on the result.
- R3: For 1 ≤ A < p with gcd(A, p) = 1, the result satisfies z_o < p and (A·z_o) mod p = 1, and equals the reference inverse.
- R4: The edge operands give exact results: A = 1 yields z_o = 1, and A = p−1 yields z_o = p−1.
- R5: A = 0 completes with err_o = 1 and z_o = 0.
- R6: When gcd(A, p) > 1, the remainder chain reaches 0 without passing through 1, and the operation completes with err_o = 1 and z_o = 0.
- R7: done_o is high for exactly one cycle per accepted start. busy_o is low in that cycle.
- R8: Between completions, z_o and err_o hold their values.
- R9: A modulus p < 2 completes with err_o = 1 and z_o = 0 after no division.
- R10: Let k be the number of divisions the algorithm performs, counting from (p, A) until the divisor is 1 or 0. Count the edge that samples start as edge 1. done_o is then high after edge k·(2N+4)+3 on success and after edge k·(2N+4)+2 on error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request; accepted only while idle |
| a_i | input | N | Operand to invert |
| p_i | input | N | Modulus |
| busy_o | output | 1 | High while an operation is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | No inverse exists; valid from done_o on |
| z_o | output | N | Inverse in [0, p); 0 on error |

## Verification
The bound checker watches on every cycle the protocol properties that need no arithmetic: start sets busy, done is a single pulse that coincides with busy falling, the outputs hold while idle, an error result is zero, and a good result lies below the captured modulus. Only the bench's scenarios can show that the value is the true inverse. This covers the edge operands 1 and p−1, moduli of 8-, 16- and 31-bit size, the common-factor and zero-operand errors, and a start ignored mid-run. Only the bench, with its behavioural model, can also show that the completion cycle matches the data-dependent iteration count.

// File: rtl/modinv_pkg.sv
`timescale 1ns/1ps
package modinv_pkg;

    // Control sequence of the inverter
    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for a start request
        ST_CHECK,  // inspect divisor: finish, fail or divide
        ST_DIV,    // division in progress
        ST_MUL,    // quotient * coefficient in progress
        ST_FIX     // map signed coefficient into [0, p)
    } inv_state_e;

    // Remainder pair held by the iteration
    typedef struct packed {
        logic [63:0] older;
        logic [63:0] newer;
    } rem_pair_t;

    // Cycles of one full iteration for an N-bit datapath
    function automatic int iter_cycles(input int n);
        return 2 * n + 4;
    endfunction

endpackage

// File: rtl/modinv_div.sv
`timescale 1ns/1ps
// Restoring shift-subtract divider: N step cycles, then a one-cycle fin pulse.
module modinv_div #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go,
    input  logic [N-1:0] dividend,
    input  logic [N-1:0] divisor,
    output logic         fin,
    output logic [N-1:0] quot,
    output logic [N-1:0] rema
);
    localparam int CW = $clog2(N + 1);

    logic [CW-1:0] cnt_q;
    logic          run_q;
    logic [N-1:0]  quo_q, rem_q, dvs_q;
    logic [N:0]    shifted, diff;
    logic          take;

    always_comb begin
        shifted = {rem_q, quo_q[N-1]};
        diff    = shifted - {1'b0, dvs_q};
        take    = (shifted >= {1'b0, dvs_q});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            run_q <= 1'b0;
            fin   <= 1'b0;
            quo_q <= '0;
            rem_q <= '0;
            dvs_q <= '0;
        end else begin
            fin <= 1'b0;
            if (go) begin
                quo_q <= dividend;
                rem_q <= '0;
                dvs_q <= divisor;
                cnt_q <= CW'(N);
                run_q <= 1'b1;
            end else if (run_q) begin
                if (take) begin
                    rem_q <= diff[N-1:0];
                    quo_q <= {quo_q[N-2:0], 1'b1};
                end else begin
                    rem_q <= shifted[N-1:0];
                    quo_q <= {quo_q[N-2:0], 1'b0};
                end
                cnt_q <= cnt_q - CW'(1);
                if (cnt_q == CW'(1)) begin
                    run_q <= 1'b0;
                    fin   <= 1'b1;
                end
            end
        end
    end

    assign quot = quo_q;
    assign rema = rem_q;
endmodule

// File: rtl/modinv_mul.sv
`timescale 1ns/1ps
// Sequential shift-add multiplier: unsigned N-bit multiplier times an
// (N+1)-bit two's-complement multiplicand, product kept modulo 2^(N+1).
module modinv_mul #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go,
    input  logic [N-1:0] mplr,
    input  logic [N:0]   mcand,
    output logic         fin,
    output logic [N:0]   prod
);
    localparam int CW = $clog2(N + 1);

    logic [CW-1:0] cnt_q;
    logic          run_q;
    logic [N-1:0]  mp_q;
    logic [N:0]    mc_q, acc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            run_q <= 1'b0;
            fin   <= 1'b0;
            mp_q  <= '0;
            mc_q  <= '0;
            acc_q <= '0;
        end else begin
            fin <= 1'b0;
            if (go) begin
                mp_q  <= mplr;
                mc_q  <= mcand;
                acc_q <= '0;
                cnt_q <= CW'(N);
                run_q <= 1'b1;
            end else if (run_q) begin
                if (mp_q[0])
                    acc_q <= acc_q + mc_q;
                mc_q  <= {mc_q[N-1:0], 1'b0};
                mp_q  <= {1'b0, mp_q[N-1:1]};
                cnt_q <= cnt_q - CW'(1);
                if (cnt_q == CW'(1)) begin
                    run_q <= 1'b0;
                    fin   <= 1'b1;
                end
            end
        end
    end

    assign prod = acc_q;
endmodule

// File: rtl/modinv_top.sv
`timescale 1ns/1ps
module modinv_top #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic [N-1:0] a_i,
    input  logic [N-1:0] p_i,
    output logic         busy_o,
    output logic         done_o,
    output logic         err_o,
    output logic [N-1:0] z_o
);
    import modinv_pkg::*;

    localparam int CW = N + 1;   // signed coefficient width

    inv_state_e    st_q;
    logic [N-1:0]  a_q, b_q, p_q, q_q;
    logic [CW-1:0] tp_q, tc_q;       // coefficient one-before-last, latest
    logic          busy_q, done_q, err_q, mul_go_q;
    logic [N-1:0]  z_q;

    logic          div_go, div_fin, mul_fin;
    logic [N-1:0]  div_quot, div_rem;
    logic [CW-1:0] mul_prod, tc_adj;
    logic          no_inverse, unit_divisor;

    always_comb begin
        no_inverse   = (p_q < N'(2)) || (b_q == '0);
        unit_divisor = (b_q == N'(1));
        div_go       = (st_q == ST_CHECK) && !no_inverse && !unit_divisor;
        tc_adj       = tc_q + {1'b0, p_q};
    end

    modinv_div #(.N(N)) div_i (
        .clk      (clk),
        .rst      (rst),
        .go       (div_go),
        .dividend (a_q),
        .divisor  (b_q),
        .fin      (div_fin),
        .quot     (div_quot),
        .rema     (div_rem)
    );

    modinv_mul #(.N(N)) mul_i (
        .clk   (clk),
        .rst   (rst),
        .go    (mul_go_q),
        .mplr  (q_q),
        .mcand (tc_q),
        .fin   (mul_fin),
        .prod  (mul_prod)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            a_q      <= '0;
            b_q      <= '0;
            p_q      <= '0;
            q_q      <= '0;
            tp_q     <= '0;
            tc_q     <= '0;
            busy_q   <= 1'b0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
            mul_go_q <= 1'b0;
            z_q      <= '0;
        end else begin
            done_q   <= 1'b0;
            mul_go_q <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (start_i) begin
                        a_q    <= p_i;
                        b_q    <= a_i;
                        p_q    <= p_i;
                        tp_q   <= '0;
                        tc_q   <= CW'(1);
                        busy_q <= 1'b1;
                        st_q   <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (no_inverse) begin
                        z_q    <= '0;
                        err_q  <= 1'b1;
                        done_q <= 1'b1;
                        busy_q <= 1'b0;
                        st_q   <= ST_IDLE;
                    end else if (unit_divisor) begin
                        st_q <= ST_FIX;
                    end else begin
                        st_q <= ST_DIV;
                    end
                end
                ST_DIV: begin
                    if (div_fin) begin
                        q_q      <= div_quot;
                        a_q      <= b_q;
                        b_q      <= div_rem;
                        mul_go_q <= 1'b1;
                        st_q     <= ST_MUL;
                    end
                end
                ST_MUL: begin
                    if (mul_fin) begin
                        tp_q <= tc_q;
                        tc_q <= tp_q - mul_prod;
                        st_q <= ST_CHECK;
                    end
                end
                ST_FIX: begin
                    z_q    <= tc_q[N] ? tc_adj[N-1:0] : tc_q[N-1:0];
                    err_q  <= 1'b0;
                    done_q <= 1'b1;
                    busy_q <= 1'b0;
                    st_q   <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign busy_o = busy_q;
    assign done_o = done_q;
    assign err_o  = err_q;
    assign z_o    = z_q;
endmodule

// File: rtl/modinv_chk.sv
`timescale 1ns/1ps
module modinv_chk #(
    parameter int N = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         start_i,
    input logic         busy_o,
    input logic         done_o,
    input logic         err_o,
    input logic [N-1:0] z_o,
    input logic [N-1:0] p_q
);
    // R2: accepted start raises busy
    a_r2_start_sets_busy: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> busy_o);

    // R7: done lasts one cycle
    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R7: busy is low when done is reported
    a_r7_done_not_busy: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    // R7: completion ends a busy period
    a_r7_done_after_busy: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> $fell(busy_o));

    // R8: idle without a request holds the outputs
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !start_i) |=> ($stable(z_o) && $stable(err_o)));

    // R3: a good result lies below the captured modulus
    a_r3_below_modulus: assert property (@(posedge clk) disable iff (rst)
        (done_o && !err_o) |-> (z_o < p_q));

    // R5, R6, R9: an error result is zero
    a_r5_err_zero: assert property (@(posedge clk) disable iff (rst)
        (done_o && err_o) |-> (z_o == '0));
endmodule

bind modinv_top modinv_chk #(.N(N)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .err_o   (err_o),
    .z_o     (z_o),
    .p_q     (p_q)
);

// File: tb/modinv_tb_top.sv
`timescale 1ns/1ps
module modinv_tb_top;
    localparam int N = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_i = 1'b0;
    logic [N-1:0] a_i = '0;
    logic [N-1:0] p_i = '0;
    logic         busy_o, done_o, err_o;
    logic [N-1:0] z_o;

    int    n_vec = 0;
    int    n_bad = 0;
    int    cyc = 0;
    string cur_tag = "R3";

    always #2.5 clk = ~clk;

    modinv_top #(.N(N)) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .a_i(a_i), .p_i(p_i),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .z_o(z_o)
    );

    // Behavioural extended Euclid: number of divisions, success, inverse
    function automatic void ref_calc(input longint a, input longint p,
                                     output int k, output bit ok, output longint z);
        longint r0 = p, r1 = a, t0 = 0, t1 = 1, q, tmp;
        k = 0; ok = 0; z = 0;
        if (p < 2) return;
        forever begin
            if (r1 == 0) return;
            if (r1 == 1) begin
                ok = 1;
                z = (t1 < 0) ? t1 + p : t1;
                return;
            end
            q = r0 / r1;
            tmp = r0 - q * r1; r0 = r1; r1 = tmp;
            tmp = t0 - q * t1; t0 = t1; t1 = tmp;
            k++;
        end
    endfunction

    task automatic check(input bit good, input string tag, input longint act, input longint exp);
        n_vec++;
        if (!good) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle reference model, advanced on each rising edge
    bit     m_busy = 0, m_done = 0, m_err = 0, pend_ok = 0;
    longint m_z = 0, pend_z = 0;
    int     m_left = 0;

    always @(posedge clk) begin
        int kk; bit okk; longint zz;
        cyc++;
        m_done = 0;
        if (rst) begin
            m_busy = 0; m_z = 0; m_err = 0; m_left = 0;
        end else if (m_busy) begin
            m_left--;
            if (m_left == 0) begin
                m_busy = 0; m_done = 1;
                m_z = pend_ok ? pend_z : 0;
                m_err = !pend_ok;
            end
        end else if (start_i) begin
            ref_calc(longint'(a_i), longint'(p_i), kk, okk, zz);
            pend_ok = okk; pend_z = zz;
            m_left = kk * (2 * N + 4) + (okk ? 3 : 2) - 1;
            m_busy = 1;
        end
    end

    // Compare on every falling edge
    always @(negedge clk) begin
        if (!rst) begin
            check(busy_o == m_busy, "R2", longint'(busy_o), longint'(m_busy));
            check(done_o == m_done, "R10", longint'(done_o), longint'(m_done));
            if (!m_busy) begin
                check(z_o == m_z[N-1:0], m_done ? cur_tag : "R8", longint'(z_o), m_z);
                check(err_o == m_err, m_done ? cur_tag : "R8", longint'(err_o), longint'(m_err));
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        if (cyc > 190000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected < 190000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic run_op(input logic [N-1:0] a, input logic [N-1:0] p,
                          input string tag, input bit poke);
        int k; bit ok; longint z; bit seen = 0;
        cur_tag = tag;
        ref_calc(longint'(a), longint'(p), k, ok, z);
        @(negedge clk); a_i = a; p_i = p; start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        if (poke) begin
            // R2: a request during busy must be ignored
            repeat (3) @(negedge clk);
            a_i = a ^ 32'h5; p_i = p + 2; start_i = 1'b1;
            @(negedge clk); start_i = 1'b0;
        end
        for (int i = 0; i < 20000; i++) begin
            if (done_o) begin seen = 1; break; end
            @(negedge clk);
        end
        check(seen, "R7", longint'(seen), 1);
        if (seen && ok)
            check((longint'(a) * longint'(z_o)) % longint'(p) == 1 && z_o < p,
                  tag, longint'(z_o), z);
        if (seen && !ok)
            check(err_o == 1'b1 && z_o == '0, tag, longint'(z_o), 0);
        @(negedge clk);
        check(!done_o, "R7", longint'(done_o), 0);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        logic [N-1:0] primes [6];
        primes[0] = 251; primes[1] = 13; primes[2] = 65521;
        primes[3] = 7919; primes[4] = 2147483647; primes[5] = 998244353;

        repeat (3) @(negedge clk);
        // R1: outputs during reset
        check(!busy_o && !done_o && !err_o && z_o == '0, "R1", longint'(z_o), 0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy_o && !done_o && !err_o && z_o == '0, "R1", longint'(z_o), 0);

        foreach (primes[j]) begin
            run_op(32'd1, primes[j], "R4", 1'b0);
            run_op(primes[j] - 1, primes[j], "R4", 1'b0);
        end
        run_op(32'd1, 32'd2, "R4", 1'b0);
        run_op(32'd0, 32'd251, "R5", 1'b0);
        run_op(32'd14, 32'd21, "R6", 1'b0);
        run_op(32'd4096, 32'd65536, "R6", 1'b0);
        run_op(32'd1, 32'd1, "R9", 1'b0);
        run_op(32'd5, 32'd0, "R9", 1'b0);
        run_op(32'd100, 32'd65521, "R2", 1'b1);
        run_op(32'd123456, 32'd2147483647, "R2", 1'b1);

        for (int i = 0; i < 30; i++) begin
            logic [N-1:0] p = primes[i % 6];
            logic [N-1:0] a = ($urandom % (p - 1)) + 1;
            run_op(a, p, "R3", 1'b0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule